// File: doc/BRIEF.md
# Memory Bus Clock and Strobe Timer

This block times one external memory access from a fast functional clock. A single-cycle start pulse begins the access. From then on the block produces a divided bus clock and one active-low control strobe. When the access is over it raises a one-cycle done flag.

The bus clock runs at 1/1, 1/2, 1/3 or 1/4 of the functional clock. Its first rising edge can be held back by 0, 1 or 2 functional cycles. The strobe is placed by its own assert and release counts in functional cycles, and these counts can be doubled by a granularity bit. The strobe edges are not moved onto bus-clock edges, so the user must pick values that give the alignment the memory needs.

Cycle numbering used below: access cycle 0 is the functional-clock cycle that follows the rising edge on which `start` is sampled high while the block is idle. N is the divide ratio, D the effective activation delay, ON and OFF the effective strobe counts.

Top module: `busclk_strobe_timer`

## Requirements
- R1: `clk_div` value k (0 to 3) gives a bus-clock period of N = k+1 functional cycles. In each period the bus clock is high for the first (N+1)/2 cycles, rounded down, and low for the rest. With N = 1 the bus clock is the functional clock passed through a glitch-free gate.
- R2: `act_delay` values 0, 1 and 2 put the first high phase of the bus clock in access cycle 0, 1 or 2 (D = act_delay).
- R3: `act_delay` = 3 is reserved. It is treated as D = 0, and `cfg_err` reads 1 from cycle 0 of that access until the next accepted start. An accepted start with any other delay sets `cfg_err` to 0.
- R4: `strobe_n` is low in exactly the access cycles c with ON <= c < OFF, and high in every other cycle.
- R5: With `gran_x2` = 1, ON = 2*`on_cnt` and OFF = 2*`off_cnt`. With `gran_x2` = 0, ON = `on_cnt` and OFF = `off_cnt`.
- R6: If OFF <= ON, `strobe_n` stays high for the whole access.
- R7: The access ends at cycle E, the first cycle c >= OFF in which c < D or (c-D) mod N = 0. The bus clock is low in cycle E, after it, and outside any access.
- R8: `done` is high in cycle E only, for one cycle.
- R9: A start pulse seen in any cycle from 0 to E is ignored. The outputs follow the first access unchanged, and no second access follows.
- R10: While `rst` is high the block is idle: bus clock low, `strobe_n` high, `done` low and `cfg_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast functional clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Access start pulse |
| clk_div | input | 2 | Bus-clock divide select (ratio = value + 1) |
| act_delay | input | 2 | First bus-clock edge delay in functional cycles |
| gran_x2 | input | 1 | Doubles the strobe counts |
| on_cnt | input | TW | Strobe assert cycle |
| off_cnt | input | TW | Strobe release cycle |
| bus_clk | output | 1 | Gated, divided bus clock |
| strobe_n | output | 1 | Active-low control strobe |
| done | output | 1 | One-cycle end-of-access flag |
| cfg_err | output | 1 | Reserved activation delay was used |

## Verification
The checker assumes that `start` and every configuration input are stable around each rising edge of `clk`. It also assumes the configuration matters only on the edge that accepts a start, and that `bus_clk` is observed only while `clk` is high. The bench changes inputs two nanoseconds after a rising edge and samples five nanoseconds after it. On an ignored start it changes the configuration inputs on purpose, to show that they are latched and not read again.

// File: rtl/bst_pkg.sv
package bst_pkg;

  // Divide ratio for a 2-bit select: 1..4
  function automatic logic [2:0] ratio_of(input logic [1:0] sel);
    return {1'b0, sel} + 3'd1;
  endfunction

  // High cycles per bus-clock period: floor((ratio+1)/2)
  function automatic logic [1:0] high_len(input logic [1:0] sel);
    return sel[1] ? 2'd2 : 2'd1;
  endfunction

  // Effective activation delay; reserved code 3 behaves as 0
  function automatic logic [1:0] delay_of(input logic [1:0] d);
    return (d == 2'd3) ? 2'd0 : d;
  endfunction

  function automatic logic is_reserved(input logic [1:0] d);
    return d == 2'd3;
  endfunction

endpackage

// File: rtl/bst_sequencer.sv
module bst_sequencer
  import bst_pkg::*;
#(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [1:0]    clk_div,
  input  logic [1:0]    act_delay,
  input  logic          gran_x2,
  input  logic [TW-1:0] on_cnt,
  input  logic [TW-1:0] off_cnt,
  output logic          busy,
  output logic          acc_start,
  output logic          end_now,
  output logic          nx_hi,
  output logic          nx_low,
  output logic          nx_done,
  output logic          div1,
  output logic          cfg_err
);
  localparam int EW = TW + 1;
  localparam int CW = TW + 2;

  function automatic logic [EW-1:0] scale(input logic [TW-1:0] v, input logic g);
    return g ? {v, 1'b0} : {1'b0, v};
  endfunction

  logic          busy_q, err_q;
  logic [CW-1:0] cnt_q;
  logic [1:0]    ph_q, sel_q, dly_q;
  logic [EW-1:0] on_q, off_q;

  // configuration that applies to the next cycle
  logic [1:0]    sel_c, dly_c;
  logic [EW-1:0] on_c, off_c;
  logic          nx_busy, nx_end;
  logic [CW-1:0] nx_cnt, cnt_inc;
  logic [1:0]    nx_ph;

  assign acc_start = start & ~busy_q;
  assign sel_c     = acc_start ? clk_div                  : sel_q;
  assign dly_c     = acc_start ? delay_of(act_delay)      : dly_q;
  assign on_c      = acc_start ? scale(on_cnt, gran_x2)   : on_q;
  assign off_c     = acc_start ? scale(off_cnt, gran_x2)  : off_q;

  assign end_now = busy_q && (cnt_q >= {1'b0, off_q}) && (ph_q == 2'd0);
  assign cnt_inc = cnt_q + 1'b1;

  always_comb begin
    nx_busy = acc_start | (busy_q & ~end_now);
    nx_cnt  = '0;
    nx_ph   = 2'd0;
    if (!acc_start && busy_q && !end_now) begin
      nx_cnt = cnt_inc;
      if (cnt_inc > CW'(dly_q)) begin
        nx_ph = ({1'b0, ph_q} == ratio_of(sel_q) - 3'd1) ? 2'd0 : ph_q + 2'd1;
      end
    end
  end

  assign nx_end  = nx_busy && (nx_cnt >= {1'b0, off_c}) && (nx_ph == 2'd0);
  assign nx_done = nx_end;
  assign nx_hi   = nx_busy && !nx_end && (nx_cnt >= CW'(dly_c))
                   && (nx_ph < high_len(sel_c));
  assign nx_low  = nx_busy && !nx_end && (nx_cnt >= {1'b0, on_c})
                   && (nx_cnt < {1'b0, off_c});

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      ph_q   <= 2'd0;
      sel_q  <= 2'd0;
      dly_q  <= 2'd0;
      on_q   <= '0;
      off_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      busy_q <= nx_busy;
      cnt_q  <= nx_cnt;
      ph_q   <= nx_ph;
      if (acc_start) begin
        sel_q <= sel_c;
        dly_q <= dly_c;
        on_q  <= on_c;
        off_q <= off_c;
        err_q <= is_reserved(act_delay);
      end
    end
  end

  assign busy    = busy_q;
  assign div1    = (sel_q == 2'd0);
  assign cfg_err = err_q;

endmodule

// File: rtl/bst_outstage.sv
module bst_outstage (
  input  logic clk,
  input  logic rst,
  input  logic nx_hi,
  input  logic nx_low,
  input  logic nx_done,
  input  logic div1,
  output logic bus_clk,
  output logic bus_hi,
  output logic strobe_n,
  output logic done
);
  logic hi_q, strb_q, done_q, en_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q   <= 1'b0;
      strb_q <= 1'b1;
      done_q <= 1'b0;
    end else begin
      hi_q   <= nx_hi;
      strb_q <= ~nx_low;
      done_q <= nx_done;
    end
  end

  // gate enable changes only while clk is low
  always_ff @(negedge clk) begin
    if (rst) en_lo <= 1'b0;
    else     en_lo <= nx_hi;
  end

  assign bus_clk  = div1 ? (clk & en_lo) : hi_q;
  assign bus_hi   = hi_q;
  assign strobe_n = strb_q;
  assign done     = done_q;

endmodule

// File: rtl/busclk_strobe_timer.sv
module busclk_strobe_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [1:0]    clk_div,
  input  logic [1:0]    act_delay,
  input  logic          gran_x2,
  input  logic [TW-1:0] on_cnt,
  input  logic [TW-1:0] off_cnt,
  output logic          bus_clk,
  output logic          strobe_n,
  output logic          done,
  output logic          cfg_err
);
  // named internal events
  logic busy, acc_start, end_now;
  logic nx_hi, nx_low, nx_done, div1, bus_hi;

  bst_sequencer #(.TW(TW)) seq_i (
    .clk(clk), .rst(rst), .start(start), .clk_div(clk_div),
    .act_delay(act_delay), .gran_x2(gran_x2), .on_cnt(on_cnt),
    .off_cnt(off_cnt), .busy(busy), .acc_start(acc_start),
    .end_now(end_now), .nx_hi(nx_hi), .nx_low(nx_low),
    .nx_done(nx_done), .div1(div1), .cfg_err(cfg_err)
  );

  bst_outstage out_i (
    .clk(clk), .rst(rst), .nx_hi(nx_hi), .nx_low(nx_low),
    .nx_done(nx_done), .div1(div1), .bus_clk(bus_clk),
    .bus_hi(bus_hi), .strobe_n(strobe_n), .done(done)
  );

endmodule

// File: rtl/bst_checker.sv
module bst_checker (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic [1:0] act_delay,
  input logic       busy,
  input logic       acc_start,
  input logic       end_now,
  input logic       bus_hi,
  input logic       strobe_n,
  input logic       done,
  input logic       cfg_err
);
  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> strobe_n && !bus_hi && end_now);

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !busy |-> strobe_n && !bus_hi && !done);

  assert_strobe_inside_R4: assert property (@(posedge clk) disable iff (rst)
    !strobe_n |-> busy && !done);

  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |-> !acc_start);

  assert_reserved_flag_R3: assert property (@(posedge clk) disable iff (rst)
    (acc_start && act_delay == 2'd3) |=> cfg_err);

  assert_reserved_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (acc_start && act_delay != 2'd3) |=> !cfg_err);

  assert_reset_idle_R10: assert property (@(posedge clk)
    rst |=> strobe_n && !bus_hi && !done && !cfg_err);

endmodule

bind busclk_strobe_timer bst_checker chk_i (
  .clk(clk), .rst(rst), .start(start), .act_delay(act_delay),
  .busy(busy), .acc_start(acc_start), .end_now(end_now),
  .bus_hi(bus_hi), .strobe_n(strobe_n), .done(done), .cfg_err(cfg_err)
);

// File: tb/busclk_strobe_timer_tb_top.sv
module busclk_strobe_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [1:0] clk_div = 2'd0, act_delay = 2'd0;
  logic       gran_x2 = 1'b0;
  logic [7:0] on_cnt = 8'd0, off_cnt = 8'd0;
  logic       bus_clk, strobe_n, done, cfg_err;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  busclk_strobe_timer #(.TW(8)) dut_i (
    .clk(clk), .rst(rst), .start(start), .clk_div(clk_div),
    .act_delay(act_delay), .gran_x2(gran_x2), .on_cnt(on_cnt),
    .off_cnt(off_cnt), .bus_clk(bus_clk), .strobe_n(strobe_n),
    .done(done), .cfg_err(cfg_err)
  );

  typedef struct packed {
    logic [1:0] dv;
    logic [1:0] dl;
    logic       gr;
    logic [7:0] on;
    logic [7:0] of;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd0, 1'b0, 8'd2, 8'd5},   // R1 div1
    '{2'd1, 2'd0, 1'b0, 8'd1, 8'd6},   // R1 div2
    '{2'd2, 2'd1, 1'b0, 8'd2, 8'd7},   // R1 R2 div3 delay1
    '{2'd3, 2'd2, 1'b0, 8'd3, 8'd9},   // R1 R2 div4 delay2
    '{2'd3, 2'd3, 1'b0, 8'd0, 8'd4},   // R3 reserved delay
    '{2'd1, 2'd2, 1'b1, 8'd2, 8'd5},   // R5 doubled
    '{2'd2, 2'd0, 1'b0, 8'd5, 8'd5},   // R6 equal
    '{2'd0, 2'd1, 1'b0, 8'd6, 8'd2},   // R6 off below on
    '{2'd3, 2'd0, 1'b1, 8'd0, 8'd0},   // R7 R8 empty access
    '{2'd2, 2'd2, 1'b1, 8'd1, 8'd3}    // R5 R7 mixed
  };

  task automatic chk(input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", what, act, exp);
    end
  endtask

  // expected timing, restated from the requirements
  function automatic int eff_d(vec_t v);
    return (v.dl == 2'd3) ? 0 : int'(v.dl);
  endfunction
  function automatic int eff_on(vec_t v);
    return v.gr ? 2 * int'(v.on) : int'(v.on);
  endfunction
  function automatic int eff_off(vec_t v);
    return v.gr ? 2 * int'(v.of) : int'(v.of);
  endfunction
  function automatic int end_cyc(vec_t v);
    int n = int'(v.dv) + 1;
    for (int c = 0; c < 2000; c++)
      if (c >= eff_off(v) && (c < eff_d(v) || ((c - eff_d(v)) % n) == 0))
        return c;
    return 0;
  endfunction
  function automatic logic exp_hi(vec_t v, int c);
    int n = int'(v.dv) + 1;
    return (c < end_cyc(v)) && (c >= eff_d(v)) && (((c - eff_d(v)) % n) < (n + 1) / 2);
  endfunction
  function automatic logic exp_low(vec_t v, int c);
    return (c < end_cyc(v)) && (c >= eff_on(v)) && (c < eff_off(v));
  endfunction

  task automatic run_access(input vec_t v, input int inject, input string tag);
    int e = end_cyc(v);
    @(posedge clk); #2;
    clk_div = v.dv; act_delay = v.dl; gran_x2 = v.gr;
    on_cnt = v.on; off_cnt = v.of; start = 1'b1;
    @(posedge clk); #2; start = 1'b0; #3;
    chk($sformatf("%s R3 cfg_err", tag), cfg_err, v.dl == 2'd3);
    for (int c = 0; c <= e + 3; c++) begin
      if (c > 0) begin
        @(posedge clk); #5;
        start = 1'b0;
      end
      chk($sformatf("%s R1 R2 R7 bus_clk c=%0d", tag, c), bus_clk, exp_hi(v, c));
      chk($sformatf("%s R4 R5 R6 strobe_n c=%0d", tag, c), strobe_n, ~exp_low(v, c));
      chk($sformatf("%s R8 done c=%0d", tag, c), done, c == e);
      if (c == inject || (inject >= 0 && c == e)) begin
        // R9: foreign start with a different configuration
        start = 1'b1; clk_div = 2'd0; act_delay = 2'd3;
        gran_x2 = ~v.gr; on_cnt = 8'd1; off_cnt = 8'd40;
      end
    end
  endtask

  initial begin
    #(20 * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R10 reset state
    repeat (3) @(posedge clk);
    #5;
    chk("R10 reset bus_clk", bus_clk, 1'b0);
    chk("R10 reset strobe_n", strobe_n, 1'b1);
    chk("R10 reset done", done, 1'b0);
    chk("R10 reset cfg_err", cfg_err, 1'b0);
    @(posedge clk); #2; rst = 1'b0;

    for (int i = 0; i < NV; i++)
      run_access(VECS[i], -1, $sformatf("vec%0d", i));

    // R9: start during access (cycle 3 and done cycle)
    run_access(VECS[3], 3, "R9 ignore");

    // R10: reset in the middle of an access after reserved delay
    @(posedge clk); #2;
    clk_div = 2'd3; act_delay = 2'd3; gran_x2 = 1'b0;
    on_cnt = 8'd1; off_cnt = 8'd30; start = 1'b1;
    @(posedge clk); #2; start = 1'b0;
    repeat (3) @(posedge clk);
    #5;
    chk("R3 flag before mid reset", cfg_err, 1'b1);
    chk("R4 strobe low before mid reset", strobe_n, 1'b0);
    rst = 1'b1;
    @(posedge clk); #5;
    chk("R10 mid reset bus_clk", bus_clk, 1'b0);
    chk("R10 mid reset strobe_n", strobe_n, 1'b1);
    chk("R10 mid reset done", done, 1'b0);
    chk("R10 mid reset cfg_err", cfg_err, 1'b0);
    @(posedge clk); #2; rst = 1'b0;

    // access after reset runs normally
    run_access(VECS[1], -1, "R10 after reset");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule